// File: doc/BRIEF.md
# Channel Setting Staleness Tracker

This block holds one staleness flag for each of 32 measurement channels. A flag goes up when any setting of its channel changes, for example a frequency span or a filter bandwidth. It comes down only when a sweep finishes on that channel without being aborted, and that sweep must have begun after the latest setting change. Each flag is a small three-state machine. Its states are CH_CLEAN (data matches the settings), CH_STALE (settings changed and no sweep has begun since) and CH_ARMED (a sweep began after the last change).

The transitions are named as follows:
- CLEAN→STALE on `mark`: a setting-change strobe in any state.
- STALE→ARMED on `arm`: a sweep-start strobe while stale.
- ARMED→STALE on `drop`: an abort strobe while armed.
- ARMED→CLEAN on `settle`: a completion strobe while armed.

In every other case a machine holds its state. A setting change outranks an abort, and an abort outranks a completion.

The flags are spread over three 15-bit status registers. Each register has a condition view, a sticky event view that is loaded through rising-edge and falling-edge filters, an enable mask and a read-clear strobe. Register 1 also carries two summary bits, one for each of the other two registers. A single summary output reports register 1.

Top module: `stale_tracker`

## Requirements
- R1: A setting-change strobe on channel c makes that channel's condition bit 1 on the clock edge that samples it.
- R2: A completion strobe in state CH_ARMED, with no change or abort in the same cycle, clears the channel's condition bit on that edge.
- R3: An abort in CH_ARMED returns the channel to CH_STALE. A completion that arrives later, with no new sweep start, leaves the bit at 1.
- R4: A completion in CH_STALE has no effect, so the bit stays at 1.
- R5: A setting change in the same cycle as a completion keeps the bit at 1, and a fresh sweep start is then needed.
- R6: Field layout of cond_o. Register k (1 to 3) occupies cond_o[(k-1)*15 +: 15].
  - Register 1: channels 1 to 13 in bits 1 to 13.
  - Register 2: channels 14 to 28 in bits 0 to 14.
  - Register 3: channels 29 to 32 in bits 1 to 4. Its bits 0 and 5 to 14 read 0.
- R7: An event bit is set one edge after its condition bit rises while its rise-filter bit is 1, or falls while its fall-filter bit is 1. An event bit never sets in any other case, and once set it stays set until it is cleared.
- R8: A read-clear strobe for register k clears its event bits. A new filtered edge in the same cycle still sets its bit.
- R9: Summary bits.
  - Condition bit 0 of register 1 is the OR of the enabled event bits of register 3.
  - Condition bit 14 of register 1 is the OR of the enabled event bits of register 2.
  - summary_o is the OR of the enabled event bits of register 1.
- R10: After reset, all flags are clean and all event bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_i | input | 32 | Per-channel setting-change strobe |
| start_i | input | 32 | Per-channel sweep-start strobe |
| done_i | input | 32 | Per-channel sweep-complete strobe |
| abort_i | input | 32 | Per-channel sweep-abort strobe |
| ptr_i | input | 45 | Rise filters, 15 bits per register |
| ntr_i | input | 45 | Fall filters, 15 bits per register |
| en_i | input | 45 | Enable masks, 15 bits per register |
| rd_i | input | 3 | Per-register event read-clear strobe |
| cond_o | output | 45 | Condition views of the three registers |
| evt_o | output | 45 | Event views of the three registers |
| summary_o | output | 1 | OR of enabled events of register 1 |

## Verification
Directed sequences on single channels cover the transitions that tell the state machine apart from a plain set/clear latch:
- a completion with no sweep start;
- an abort followed by a completion;
- a change that coincides with a completion.

Channels chosen in each register check the bit placement. Their propagation through the event stage and the summary bits shows the one-edge delay per level.

Sparse random strobes on all channels, under changing filter and enable masks and random read-clears, are compared every cycle against a reference model. This exposes errors in priority, edge filtering and clear-versus-set ordering that the directed cases would not reach.

// File: rtl/stale_pkg.sv
package stale_pkg;
    localparam int REG_W    = 15;
    localparam int NUM_REG  = 3;
    localparam int R1_CH    = 13;
    localparam int R2_CH    = 15;
    localparam int R3_CH    = 4;
    localparam int NUM_CH   = R1_CH + R2_CH + R3_CH;
    localparam int R2_BASE  = R1_CH;
    localparam int R3_BASE  = R1_CH + R2_CH;
    localparam int R1_FIRST = 1;
    localparam int R2_FIRST = 0;
    localparam int R3_FIRST = 1;
    localparam int R1_SUM3  = 0;
    localparam int R1_SUM2  = REG_W - 1;
    localparam int FLAT_W   = REG_W * NUM_REG;

    typedef enum logic [1:0] {
        CH_CLEAN = 2'd0,
        CH_STALE = 2'd1,
        CH_ARMED = 2'd2
    } ch_state_e;
endpackage

// File: rtl/stale_chan_fsm.sv
module stale_chan_fsm
    import stale_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    input  logic start_i,
    input  logic done_i,
    input  logic abort_i,
    output logic flag_o
);
    ch_state_e state_q;
    ch_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (chg_i) begin
            state_d = CH_STALE;                     // mark
        end else begin
            unique case (state_q)
                CH_CLEAN: state_d = CH_CLEAN;
                CH_STALE: if (start_i) state_d = CH_ARMED;      // arm
                CH_ARMED: begin
                    if (abort_i)     state_d = CH_STALE;         // drop
                    else if (done_i) state_d = CH_CLEAN;         // settle
                end
                default:  state_d = CH_STALE;
            endcase
        end
    end

    always_comb flag_o = (state_q != CH_CLEAN);

    assert_change_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> flag_o);
    assert_settle_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARMED && done_i && !chg_i && !abort_i) |=> !flag_o);
    assert_abort_rearms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARMED && abort_i) |=> (flag_o && state_q == CH_STALE));
    assert_no_start_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STALE && !start_i) |=> flag_o);
endmodule

// File: rtl/stale_evt_reg.sv
module stale_evt_reg #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond_i,
    input  logic [W-1:0] ptr_i,
    input  logic [W-1:0] ntr_i,
    input  logic [W-1:0] en_i,
    input  logic         rd_i,
    output logic [W-1:0] ev_o,
    output logic         sum_o
);
    logic [W-1:0] cond_q;
    logic [W-1:0] set_v;

    always_comb set_v = (cond_i & ~cond_q & ptr_i) | (~cond_i & cond_q & ntr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
            ev_o   <= '0;
        end else begin
            cond_q <= cond_i;
            ev_o   <= (rd_i ? '0 : ev_o) | set_v;
        end
    end

    always_comb sum_o = |(ev_o & en_i);

    assert_evt_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_o & ~$past(ev_o)) & ~$past(set_v)) == '0);
    assert_evt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((($past(ev_o)) & ~ev_o) == '0));
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && set_v == '0) |=> ev_o == '0);
endmodule

// File: rtl/stale_tracker.sv
module stale_tracker
    import stale_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chg_i,
    input  logic [NUM_CH-1:0] start_i,
    input  logic [NUM_CH-1:0] done_i,
    input  logic [NUM_CH-1:0] abort_i,
    input  logic [FLAT_W-1:0] ptr_i,
    input  logic [FLAT_W-1:0] ntr_i,
    input  logic [FLAT_W-1:0] en_i,
    input  logic [NUM_REG-1:0] rd_i,
    output logic [FLAT_W-1:0] cond_o,
    output logic [FLAT_W-1:0] evt_o,
    output logic              summary_o
);
    logic [NUM_CH-1:0]  flag;
    logic [REG_W-1:0]   cond_r1, cond_r2, cond_r3;
    logic [NUM_REG-1:0] sum_v;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        stale_chan_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .chg_i   (chg_i[c]),
            .start_i (start_i[c]),
            .done_i  (done_i[c]),
            .abort_i (abort_i[c]),
            .flag_o  (flag[c])
        );
    end

    always_comb begin
        cond_r1 = '0;
        cond_r2 = '0;
        cond_r3 = '0;
        for (int i = 0; i < R1_CH; i++) cond_r1[R1_FIRST + i] = flag[i];
        for (int i = 0; i < R2_CH; i++) cond_r2[R2_FIRST + i] = flag[R2_BASE + i];
        for (int i = 0; i < R3_CH; i++) cond_r3[R3_FIRST + i] = flag[R3_BASE + i];
        cond_r1[R1_SUM3] = sum_v[2];
        cond_r1[R1_SUM2] = sum_v[1];
    end

    assign cond_o = {cond_r3, cond_r2, cond_r1};

    for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
        stale_evt_reg #(.W(REG_W)) u_evt (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond_i (cond_o[k*REG_W +: REG_W]),
            .ptr_i  (ptr_i[k*REG_W +: REG_W]),
            .ntr_i  (ntr_i[k*REG_W +: REG_W]),
            .en_i   (en_i[k*REG_W +: REG_W]),
            .rd_i   (rd_i[k]),
            .ev_o   (evt_o[k*REG_W +: REG_W]),
            .sum_o  (sum_v[k])
        );
    end

    assign summary_o = sum_v[0];

    assert_summary_has_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        summary_o |-> (|evt_o[REG_W-1:0]));
    assert_spare_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_o[2*REG_W] == 1'b0) && (cond_o[3*REG_W-1 : 2*REG_W+R3_FIRST+R3_CH] == '0));
endmodule

// File: tb/stale_tracker_tb.sv
`timescale 1ns/1ps
module stale_tracker_tb;
    localparam int NC = 32;
    localparam int RW = 15;
    localparam int FW = 45;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0] chg_i = '0, start_i = '0, done_i = '0, abort_i = '0;
    logic [FW-1:0] ptr_i = '0, ntr_i = '0, en_i = '0;
    logic [2:0]    rd_i = '0;
    logic [FW-1:0] cond_o, evt_o;
    logic          summary_o;

    int n_chk = 0, n_bad = 0;
    int mst [NC];
    logic [RW-1:0] mev [3];
    logic [RW-1:0] mcq [3];

    always #2.5 clk = ~clk;

    stale_tracker u_dut (.*);

    function automatic logic [RW-1:0] fld(logic [FW-1:0] v, int k);
        return v[k*RW +: RW];
    endfunction

    function automatic logic [RW-1:0] mcond(int k);
        logic [RW-1:0] c = '0;
        if (k == 0) begin
            for (int i = 0; i < 13; i++) c[1+i] = (mst[i] != 0);
            c[0]  = |(mev[2] & fld(en_i, 2));
            c[14] = |(mev[1] & fld(en_i, 1));
        end else if (k == 1) begin
            for (int i = 0; i < 15; i++) c[i] = (mst[13+i] != 0);
        end else begin
            for (int i = 0; i < 4; i++) c[1+i] = (mst[28+i] != 0);
        end
        return c;
    endfunction

    function automatic int mnext(int s, logic ch, logic st, logic dn, logic ab);
        if (ch) return 1;
        if (s == 1) return st ? 2 : 1;
        if (s == 2) return ab ? 1 : (dn ? 0 : 2);
        return 0;
    endfunction

    task automatic model_edge();
        logic [RW-1:0] c [3];
        for (int k = 0; k < 3; k++) c[k] = mcond(k);
        for (int k = 0; k < 3; k++) begin
            mev[k] = (rd_i[k] ? '0 : mev[k])
                   | (c[k] & ~mcq[k] & fld(ptr_i, k))
                   | (~c[k] & mcq[k] & fld(ntr_i, k));
            mcq[k] = c[k];
        end
        for (int i = 0; i < NC; i++) mst[i] = mnext(mst[i], chg_i[i], start_i[i], done_i[i], abort_i[i]);
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #0.5 model_edge();
        @(negedge clk);
        check("R1-cond model", 64'(cond_o), 64'({mcond(2), mcond(1), mcond(0)}));
        check("R7-event model", 64'(evt_o), 64'({mev[2], mev[1], mev[0]}));
        check("R9-summary model", 64'(summary_o), 64'(|(mev[0] & fld(en_i, 0))));
        chg_i = '0; start_i = '0; done_i = '0; abort_i = '0; rd_i = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NC; i++) mst[i] = 0;
        for (int k = 0; k < 3; k++) begin mev[k] = '0; mcq[k] = '0; end
        ptr_i = '1; ntr_i = '0; en_i = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 cond", 64'(cond_o), 64'd0);
        check("R10 evt", 64'(evt_o), 64'd0);
        check("R10 summary", 64'(summary_o), 64'd0);

        chg_i[0] = 1; step();
        check("R1 ch1 set", 64'(cond_o[1]), 64'd1);
        check("R7 no event yet", 64'(evt_o[1]), 64'd0);
        step();
        check("R7 event rise", 64'(evt_o[1]), 64'd1);
        check("R9 summary", 64'(summary_o), 64'd1);
        done_i[0] = 1; step();
        check("R4 done w/o start", 64'(cond_o[1]), 64'd1);
        start_i[0] = 1; step();
        abort_i[0] = 1; step();
        done_i[0] = 1; step();
        check("R3 abort then done", 64'(cond_o[1]), 64'd1);
        start_i[0] = 1; step();
        done_i[0] = 1; step();
        check("R2 clean after sweep", 64'(cond_o[1]), 64'd0);
        chg_i[0] = 1; step();
        start_i[0] = 1; step();
        chg_i[0] = 1; done_i[0] = 1; step();
        check("R5 change beats done", 64'(cond_o[1]), 64'd1);
        done_i[0] = 1; step();
        check("R5 new start needed", 64'(cond_o[1]), 64'd1);
        start_i[0] = 1; step();
        done_i[0] = 1; step();
        rd_i = 3'b111; step();
        check("R8 read clears", 64'(evt_o), 64'd0);
        check("R8 summary low", 64'(summary_o), 64'd0);

        chg_i[19] = 1; step();
        check("R6 ch20 at reg2 bit6", 64'(cond_o[RW+6]), 64'd1);
        step();
        check("R7 reg2 event", 64'(evt_o[RW+6]), 64'd1);
        check("R9 reg1 bit14", 64'(cond_o[14]), 64'd1);
        step();
        check("R9 summary via reg2", 64'(summary_o), 64'd1);
        chg_i[29] = 1; step();
        check("R6 ch30 at reg3 bit2", 64'(cond_o[2*RW+2]), 64'd1);
        step();
        check("R9 reg1 bit0", 64'(cond_o[0]), 64'd1);
        chg_i[13] = 1; step();
        rd_i[1] = 1; step();
        check("R8 new edge wins", 64'(evt_o[RW]), 64'd1);
        check("R8 old bit cleared", 64'(evt_o[RW+6]), 64'd0);

        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) begin
                ptr_i = {$urandom, $urandom}; ntr_i = {$urandom, $urandom}; en_i = {$urandom, $urandom};
            end
            for (int i = 0; i < NC; i++) begin
                chg_i[i]   = ($urandom % 24) == 0;
                start_i[i] = ($urandom % 6) == 0;
                done_i[i]  = ($urandom % 6) == 0;
                abort_i[i] = ($urandom % 20) == 0;
            end
            for (int k = 0; k < 3; k++) rd_i[k] = ($urandom % 8) == 0;
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule